// File: doc/BRIEF.md
# I2C Pin Expander with Output Hold

This block is an I2C target that owns a small bank of 8-bit configuration registers. It drives a vector of output pins straight from those registers. A bus controller chooses a register with a pointer byte and then writes a stream of data bytes, or it reads the registers back. Both writes and reads advance the pointer after each byte.

When the hold input is high, the block freezes the whole pin vector for the length of a transaction. The registers still commit as each byte is acknowledged. When the freeze lifts, every pin moves in the same cycle, so a burst written to several registers appears at the pins as one update.

The length of the freeze depends on the transfer type:
- A write keeps the pins frozen until the STOP.
- A read releases them once the address byte has been acknowledged.
- A repeated START begins a new freeze whose length follows the new direction bit.
- An address that does not match releases the pins at once.

Top module: `gpx_top`

## Requirements
- R1: The first byte after a START carries a 7-bit target address (bits 7..1) and a direction bit (bit 0, 1 = read). A match to DEV_ADDR is acknowledged by pulling SDA low in the ninth clock. A mismatch is not acknowledged, and every later byte up to the next START or STOP is ignored.
- R2: On a write, the byte after the address loads the register pointer from its low log2(NUM_REGS) bits. Each following data byte is stored into the pointed register at the end of its acknowledge, and then the pointer increments, wrapping modulo NUM_REGS (a power of two).
- R3: With holdEn high, every pin keeps its level from START until the write transaction ends, even though registers commit during it.
- R4: When the hold ends, all pins change together to the committed register contents, within 4 clock cycles of the ending bus event.
- R5: With holdEn low, pins[8*i+7:8*i] follows register i within 5 clock cycles of the falling SCL edge that ends each acknowledge.
- R6: A read returns the pointed register MSB first, then increments the pointer after each byte the controller acknowledges. A NACK from the controller ends the data phase, and SDA stays released until the next START or STOP.
- R7: On a read with holdEn high, the hold ends at the falling SCL edge that closes the address acknowledge.
- R8: A repeated START ends the current hold and opens a new one, whose type (write or read) follows the new direction bit.
- R9: An address mismatch ends any hold as soon as the eighth address bit has been clocked.
- R10: sdaOe high means SDA is pulled low. It is the only way the block drives SDA, and it changes only while SCL is low.
- R11: After reset, all registers, all pins and sdaOe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| holdEn | input | 1 | Enables output hold during transactions |
| sdaOe | output | 1 | Pulls SDA low when high (open drain) |
| pins | output | 8*NUM_REGS | Output pin vector, register i on bits 8*i+7..8*i |

## Verification
Bus inputs pass through two synchronising flops and one edge flop, and then through a register stage before reaching the pins. A register commit or a hold release therefore shows at the pins 4 to 5 cycles after the bus edge that causes it. The bench holds each SCL phase for 8 cycles and compares the pins only at the end of a phase, after the acknowledge clock has fallen or after a STOP. In that position a missing hold, a late release or an early update all show as a mismatch against the arithmetic register model. Read data and the acknowledge bit are sampled a full phase after SCL rises, by which time the block has driven SDA for at least 5 cycles.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RLOAD, ST_RDAT, ST_RDAT_ACK, ST_WAIT
  } busState_t;

  typedef struct packed {
    logic       ptrLoad;
    logic       ptrInc;
    logic       wrEn;
    logic       holdActive;
    logic [7:0] byteVal;
  } dpStrobe_t;

endpackage

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
  import gpx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  output dpStrobe_t  strobe,
  output logic       sdaOe
);

  localparam int SYNC_DEPTH = 2;

  logic [SYNC_DEPTH-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclQ, sdaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_DEPTH-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_DEPTH-2:0], sdaIn};
      sclPrev <= sclQ;
      sdaPrev <= sdaQ;
    end
  end

  assign sclQ = sclSync[SYNC_DEPTH-1];
  assign sdaQ = sdaSync[SYNC_DEPTH-1];

  logic startDet, stopDet, sclRise, sclFall;
  assign startDet = sclQ & sclPrev & sdaPrev & ~sdaQ;
  assign stopDet  = sclQ & sclPrev & ~sdaPrev & sdaQ;
  assign sclRise  = sclQ & ~sclPrev;
  assign sclFall  = ~sclQ & sclPrev;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic       rwBit, nackSeen, holdQ, oeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      rwBit    <= 1'b0;
      nackSeen <= 1'b0;
      holdQ    <= 1'b0;
      oeQ      <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
      holdQ <= 1'b0;
      oeQ   <= 1'b0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      holdQ  <= 1'b1;
      oeQ    <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (sclRise) begin
            shiftReg <= {shiftReg[6:0], sdaQ};
            bitCnt   <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_ADDR) begin
              if (shiftReg[7:1] == DEV_ADDR) begin
                oeQ   <= 1'b1;
                rwBit <= shiftReg[0];
                state <= ST_ADDR_ACK;
              end else begin
                state <= ST_WAIT;
                holdQ <= 1'b0;
              end
            end else begin
              oeQ   <= 1'b1;
              state <= (state == ST_PTR) ? ST_PTR_ACK : ST_WDAT_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            oeQ    <= 1'b0;
            bitCnt <= '0;
            if (rwBit) begin
              state <= ST_RLOAD;
              holdQ <= 1'b0;
            end else begin
              state <= ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDAT_ACK: begin
          if (sclFall) begin
            oeQ    <= 1'b0;
            bitCnt <= '0;
            state  <= ST_WDAT;
          end
        end
        ST_RLOAD: begin
          shiftReg <= rdByte;
          oeQ      <= ~rdByte[7];
          bitCnt   <= '0;
          nackSeen <= 1'b0;
          state    <= ST_RDAT;
        end
        ST_RDAT: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              oeQ   <= 1'b0;
              state <= ST_RDAT_ACK;
            end else begin
              shiftReg <= {shiftReg[6:0], 1'b0};
              oeQ      <= ~shiftReg[6];
            end
          end
        end
        ST_RDAT_ACK: begin
          if (sclRise) nackSeen <= sdaQ;
          else if (sclFall) state <= nackSeen ? ST_WAIT : ST_RLOAD;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.byteVal    = shiftReg;
    strobe.holdActive = holdQ;
    if (!startDet && !stopDet && sclFall) begin
      case (state)
        ST_PTR_ACK:  strobe.ptrLoad = 1'b1;
        ST_WDAT_ACK: begin
          strobe.wrEn   = 1'b1;
          strobe.ptrInc = 1'b1;
        end
        ST_RDAT_ACK: strobe.ptrInc = ~nackSeen;
        default: ;
      endcase
    end
  end

  assign sdaOe = oeQ;

  // R10: the open-drain enable moves only while SCL is low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(oeQ) |-> !sclQ);

  // R3: a START always opens a hold window
  p_start_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> holdQ);

  // R4: a STOP always closes the hold window and releases SDA
  p_stop_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!holdQ && !oeQ));

  // R9: a mismatched address drops the hold without acknowledging
  p_mismatch_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && !startDet && !stopDet && sclFall && bitCnt == 4'd8
     && shiftReg[7:1] != DEV_ADDR) |=> (!holdQ && !oeQ));

endmodule

// File: rtl/gpx_dp.sv
module gpx_dp
  import gpx_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  holdEn,
  input  dpStrobe_t             strobe,
  output logic [7:0]            rdByte,
  output logic [8*NUM_REGS-1:0] pins
);

  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int PIN_W = 8 * NUM_REGS;

  logic [7:0]       regBank [NUM_REGS];
  logic [PTR_W-1:0] ptr;
  logic [PIN_W-1:0] regVec;
  logic [PIN_W-1:0] pinQ;
  logic             freeze;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   regBank[g] <= '0;
      else if (strobe.wrEn && ptr == PTR_W'(g))    regBank[g] <= strobe.byteVal;
    end
    assign regVec[8*g +: 8] = regBank[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ptr <= '0;
    else if (strobe.ptrLoad) ptr <= strobe.byteVal[PTR_W-1:0];
    else if (strobe.ptrInc)  ptr <= ptr + 1'b1;
  end

  assign rdByte = regBank[ptr];
  assign freeze = holdEn & strobe.holdActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       pinQ <= '0;
    else if (!freeze) pinQ <= regVec;
  end

  assign pins = pinQ;

  // R3: no pin moves while a hold window is active
  p_hold_freeze_r3: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> $stable(pins));

  // R2: the pointer wraps from the last register to register 0
  p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ptrInc && !strobe.ptrLoad && ptr == PTR_W'(NUM_REGS - 1)) |=> ptr == '0);

endmodule

// File: rtl/gpx_top.sv
module gpx_top
  import gpx_pkg::*;
#(
  parameter int         NUM_REGS = 4,
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic                  holdEn,
  output logic                  sdaOe,
  output logic [8*NUM_REGS-1:0] pins
);

  dpStrobe_t  strobe;
  logic [7:0] rdByte;

  gpx_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .rdByte (rdByte),
    .strobe (strobe),
    .sdaOe  (sdaOe)
  );

  gpx_dp #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .holdEn (holdEn),
    .strobe (strobe),
    .rdByte (rdByte),
    .pins   (pins)
  );

endmodule

// File: tb/tb_gpx_top.sv
`timescale 1ns/1ps
module tb_gpx_top;

  localparam int         PH   = 8;
  localparam logic [6:0] ADDR = 7'h2A;

  logic clk = 1'b0;
  logic rstN, sclIn, holdEn, tbSdaLow;
  logic sdaOe, sdaLine;
  logic [31:0] pins;
  logic [7:0]  model [4];
  int nChk = 0, nFail = 0;

  always #2 clk = ~clk;

  assign sdaLine = ~(tbSdaLow | sdaOe);

  gpx_top #(.NUM_REGS(4), .DEV_ADDR(ADDR)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaLine),
    .holdEn(holdEn), .sdaOe(sdaOe), .pins(pins)
  );

  function automatic logic [31:0] packModel();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    tbSdaLow = 1'b0; sclIn = 1'b1; tick(PH);
    tbSdaLow = 1'b1; tick(PH);
    sclIn = 1'b0; tick(PH);
  endtask

  task automatic busRepStart();
    tbSdaLow = 1'b0; tick(PH);
    sclIn = 1'b1; tick(PH);
    tbSdaLow = 1'b1; tick(PH);
    sclIn = 1'b0; tick(PH);
  endtask

  task automatic busStop();
    tbSdaLow = 1'b1; tick(PH);
    sclIn = 1'b1; tick(PH);
    tbSdaLow = 1'b0; tick(PH);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tbSdaLow = ~b[i]; tick(PH);
      sclIn = 1'b1; tick(PH);
      sclIn = 1'b0; tick(2);
    end
    tbSdaLow = 1'b0; tick(PH);
    sclIn = 1'b1; tick(PH);
    ack = ~sdaLine;
    sclIn = 1'b0; tick(PH);
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    logic [7:0] tmp;
    tbSdaLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(PH);
      sclIn = 1'b1; tick(PH);
      tmp[i] = sdaLine;
      sclIn = 1'b0;
    end
    tick(2);
    tbSdaLow = ackIt; tick(PH);
    sclIn = 1'b1; tick(PH);
    sclIn = 1'b0; tick(2);
    tbSdaLow = 1'b0; tick(PH);
    b = tmp;
  endtask

  // R10: every change of the SDA pull-down must happen while SCL is low
  logic oePrev = 1'b0;
  always @(negedge clk) begin
    if (rstN === 1'b1 && sdaOe !== oePrev) begin
      nChk++;
      if (sclIn !== 1'b0) begin
        nFail++;
        $display("FAIL R10: actual scl %b expected 0 at sdaOe change", sclIn);
      end
    end
    oePrev <= sdaOe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    logic [31:0] old;
    int p;
    rstN = 1'b0; sclIn = 1'b1; tbSdaLow = 1'b0; holdEn = 1'b0;
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(5);
    chk("R11 pins after reset", pins, 32'h0);
    chk("R11 sdaOe after reset", {31'b0, sdaOe}, 32'h0);

    // R5 / R2: direct mode, pointer sweep with wrap
    holdEn = 1'b0;
    for (int k = 0; k < 3; k++) begin
      p = (k * 3) % 4;
      busStart();
      sendByte({ADDR, 1'b0}, ack);
      chk("R1 address ack", {31'b0, ack}, 32'h1);
      sendByte(8'(p + 4 * k), ack);
      chk("R2 pointer ack", {31'b0, ack}, 32'h1);
      for (int j = 0; j < 5; j++) begin
        logic [7:0] v;
        v = 8'((k * 53 + j * 29 + 7) & 255);
        sendByte(v, ack);
        model[(p + j) % 4] = v;
        chk("R5 pins follow after ack", pins, packModel());
      end
      busStop();
      chk("R2 registers after burst", pins, packModel());
    end

    // R6: readback with pointer wrap and final NACK
    busStart();
    sendByte({ADDR, 1'b0}, ack);
    sendByte(8'd1, ack);
    busRepStart();
    sendByte({ADDR, 1'b1}, ack);
    chk("R1 read address ack", {31'b0, ack}, 32'h1);
    for (int j = 0; j < 5; j++) begin
      readByte(j < 4, rd);
      chk("R6 read data", {24'b0, rd}, {24'b0, model[(1 + j) % 4]});
    end
    busStop();

    // R3 / R4: held write bursts
    holdEn = 1'b1;
    for (int k = 0; k < 3; k++) begin
      old = packModel();
      busStart();
      sendByte({ADDR, 1'b0}, ack);
      sendByte(8'd0, ack);
      for (int j = 0; j < 4; j++) begin
        logic [7:0] v;
        v = 8'((k * 71 + j * 17 + 3) & 255);
        sendByte(v, ack);
        model[j] = v;
        chk("R3 pins held during write", pins, old);
      end
      busStop();
      chk("R4 pins released together", pins, packModel());
    end

    // R7 / R8: write then repeated START into a read
    old = packModel();
    busStart();
    sendByte({ADDR, 1'b0}, ack);
    sendByte(8'd2, ack);
    sendByte(8'hA5, ack);
    model[2] = 8'hA5;
    chk("R3 pins held before repeated start", pins, old);
    busRepStart();
    sendByte({ADDR, 1'b1}, ack);
    chk("R8 read after repeated start acked", {31'b0, ack}, 32'h1);
    chk("R7 read hold ends after address", pins, packModel());
    readByte(1'b0, rd);
    chk("R6 read after increment", {24'b0, rd}, {24'b0, model[3]});
    busStop();

    // R8: write then repeated START into another write stays held
    old = packModel();
    busStart();
    sendByte({ADDR, 1'b0}, ack);
    sendByte(8'd0, ack);
    sendByte(8'h3C, ack);
    model[0] = 8'h3C;
    busRepStart();
    sendByte({ADDR, 1'b0}, ack);
    sendByte(8'd1, ack);
    sendByte(8'hC3, ack);
    model[1] = 8'hC3;
    chk("R8 new write window still held", pins, old);
    busStop();
    chk("R4 release after second window", pins, packModel());

    // R9 / R1: repeated START to another address drops the hold
    old = packModel();
    busStart();
    sendByte({ADDR, 1'b0}, ack);
    sendByte(8'd3, ack);
    sendByte(8'h5A, ack);
    model[3] = 8'h5A;
    chk("R3 held before mismatch", pins, old);
    busRepStart();
    sendByte({ADDR ^ 7'h01, 1'b0}, ack);
    chk("R1 mismatch not acked", {31'b0, ack}, 32'h0);
    chk("R9 hold dropped on mismatch", pins, packModel());
    busStop();

    // R1: bytes after a mismatched address are ignored
    holdEn = 1'b0;
    busStart();
    sendByte({ADDR ^ 7'h10, 1'b0}, ack);
    sendByte(8'd0, ack);
    chk("R1 ignored byte not acked", {31'b0, ack}, 32'h0);
    sendByte(8'hFF, ack);
    busStop();
    chk("R1 registers untouched", pins, packModel());

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule